// File: doc/BRIEF.md
# Compressed Instruction Expander

This block sits between instruction fetch and decode in a 32-bit RISC-V core that accepts the compressed (16-bit) encodings. Each clock it takes one fetched word. When the low two bits are not `11`, the lower half is treated as a compressed instruction and is rewritten into the equivalent full-width base instruction. Scrambled immediate fields are put back in order, 3-bit register selectors are widened to the x8–x15 (or f8–f15) window, and the implied operands x0, x1 or x2 are filled in. When the low two bits are `11`, the word is already a full-width instruction and passes through untouched, with a flag saying so.

Reserved and RV64-only encodings raise an illegal flag. In that case the expanded word is a harmless `addi x0, x0, 0`, so that decode never sees a malformed opcode. The result, the wide flag and the illegal flag are all registered and appear one clock after the input. The floating-point load/store forms for single and double precision can be removed by parameter, in which case they are reported illegal.

Top module: `rvc_expander`

## Requirements
- R1: An input whose bits 1:0 are `11` appears unchanged on `expanded_o` one clock later, with `wide_o`=1 and `illegal_o`=0; for any other input `wide_o`=0 and bits 31:16 of the input have no effect.
- R2: Outputs are registered. While `rst_i` is high at a rising edge they become `expanded_o`=0x00000013, `wide_o`=0, `illegal_o`=0. Any illegal input yields `expanded_o`=0x00000013 with `illegal_o`=1, and `expanded_o[1:0]` is always `11`.
- R3: A 3-bit register selector r in a compressed form names register 8+r, for both the integer and the floating-point register files.
- R4: Quadrant 0 funct3 000 expands to `addi rd, x2, uimm` with uimm bits [5:4]=c[12:11], [9:6]=c[10:7], [2]=c[6], [3]=c[5]; a zero uimm, including the all-zero halfword, is illegal. Quadrant 0 funct3 100 is illegal.
- R5: Word loads and stores in quadrant 0 (funct3 010 and 110) use an unsigned offset with [5:3]=c[12:10], [2]=c[6], [6]=c[5], and expand to `lw`/`sw` with funct3 010.
- R6: Quadrant 1 funct3 001 and 101 expand to `jal` with rd=x1 and rd=x0 respectively; the sign-extended offset is held in c[12:2] as offset bits 11,4,9,8,10,6,7,3,2,1,5.
- R7: Quadrant 1 funct3 110 and 111 expand to `beq`/`bne rs1', x0`; the sign-extended offset has [8]=c[12], [4:3]=c[11:10], [7:6]=c[6:5], [2:1]=c[4:3], [5]=c[2].
- R8: Quadrant 1 funct3 011 with rd=x2 expands to `addi x2, x2, imm` with imm [9]=c[12], [4]=c[6], [6]=c[5], [8:7]=c[4:3], [5]=c[2], sign-extended. With any other rd it expands to `lui rd, imm` with imm bits 17:12 = c[12], c[6:2], sign-extended. Either form with a zero immediate is illegal.
- R9: Quadrant 2 funct3 010 (stack word load) with rd=x0 is illegal; the register jump forms (quadrant 2, funct3 100, rs2=0) with rs1=x0 and c[12]=0 are illegal.
- R10: With c[15:10]=100011 in quadrant 1, c[6:5]=00/01/10/11 select `sub`/`xor`/`or`/`and rd', rd', rs2'`; with c[12]=1 (c[15:10]=100111) the input is illegal.
- R11: 0x0001 expands to 0x00000013 and is legal; 0x9002 expands to 0x00100073 (ebreak). Quadrant 2 funct3 100 with rs2≠0 expands to `add rd, x0, rs2` when c[12]=0 and to `add rd, rd, rs2` when c[12]=1. With rs2=0 and rs1≠0 it expands to `jalr x0, 0(rs1)` when c[12]=0 and to `jalr x1, 0(rs1)` when c[12]=1.
- R12: Shift-immediate forms (slli in quadrant 2; srli/srai in quadrant 1) are illegal when shift amount bit 5 (c[12]) is set. Otherwise they expand with shamt=c[6:2], and srai carries funct7 0100000. `andi`, `addi` and `li` sign-extend {c[12],c[6:2]}.
- R13: With floating-point support on, the double forms expand to LOAD-FP/STORE-FP (opcodes 0000111/0100111) with width 011 and the single forms with width 010. Stack-relative doubles use offset [5]=c[12], [4:3]=c[6:5], [8:6]=c[4:2] for loads, and [5:3]=c[12:10], [8:6]=c[9:7] for stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| fetch_word_i | input | ILEN (32) | Fetched word; only bits 15:0 matter when compressed |
| expanded_o | output | ILEN (32) | Registered full-width instruction |
| wide_o | output | 1 | Registered flag: the input was already full width |
| illegal_o | output | 1 | Registered flag: reserved or unsupported compressed encoding |

## Verification
Every result of this block is due exactly one rising edge after the word is presented, because the translation is a single combinational step feeding one register stage. The bench changes `fetch_word_i` on a falling edge. It then reads `expanded_o`, `wide_o` and `illegal_o` on the next falling edge, so each value is taken half a period after the edge that loaded it and half a period before the next input can change it. Expected words are built in the bench from the standard base-format field layouts and hand-chosen immediates, never from the expander's own bit shuffles.

// File: rtl/rvc_pkg.sv
package rvc_pkg;

  localparam int CW = 16;
  localparam int IW = 32;

  typedef logic [IW-1:0] word_t;
  typedef logic [4:0]    reg_t;

  typedef struct packed {
    word_t instr;
    logic  bad;
  } xlat_t;

  localparam logic [6:0] OPC_LOAD    = 7'b0000011;
  localparam logic [6:0] OPC_LOADFP  = 7'b0000111;
  localparam logic [6:0] OPC_OPIMM   = 7'b0010011;
  localparam logic [6:0] OPC_STORE   = 7'b0100011;
  localparam logic [6:0] OPC_STOREFP = 7'b0100111;
  localparam logic [6:0] OPC_OP      = 7'b0110011;
  localparam logic [6:0] OPC_LUI     = 7'b0110111;
  localparam logic [6:0] OPC_BRANCH  = 7'b1100011;
  localparam logic [6:0] OPC_JALR    = 7'b1100111;
  localparam logic [6:0] OPC_JAL     = 7'b1101111;

  localparam word_t NOP_WORD    = 32'h0000_0013;
  localparam word_t EBREAK_WORD = 32'h0010_0073;

  localparam reg_t X0 = 5'd0;
  localparam reg_t X1 = 5'd1;
  localparam reg_t X2 = 5'd2;

  function automatic word_t enc_i(input logic [11:0] imm, input reg_t rs1,
                                  input logic [2:0] f3, input reg_t rd,
                                  input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  function automatic word_t enc_s(input logic [11:0] imm, input reg_t rs2,
                                  input reg_t rs1, input logic [2:0] f3,
                                  input logic [6:0] op);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], op};
  endfunction

  function automatic word_t enc_r(input logic [6:0] f7, input reg_t rs2,
                                  input reg_t rs1, input logic [2:0] f3,
                                  input reg_t rd);
    return {f7, rs2, rs1, f3, rd, OPC_OP};
  endfunction

  function automatic word_t enc_b(input logic [12:0] imm, input reg_t rs1,
                                  input logic [2:0] f3);
    return {imm[12], imm[10:5], X0, rs1, f3, imm[4:1], imm[11], OPC_BRANCH};
  endfunction

  function automatic word_t enc_j(input logic [20:0] imm, input reg_t rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, OPC_JAL};
  endfunction

  // compressed 3-bit selector -> register 8..15
  function automatic reg_t widen(input logic [2:0] r);
    return {2'b01, r};
  endfunction

endpackage

// File: rtl/rvc_quad0.sv
module rvc_quad0
  import rvc_pkg::*;
#(
  parameter bit HAS_FPU = 1'b1
) (
  input  logic [15:2] c,
  output xlat_t       res
);

  logic       fp_ok;
  reg_t       rd_p;
  reg_t       rs1_p;
  logic [9:0] spn_imm;
  logic [6:0] w_off;
  logic [7:0] d_off;

  generate
    if (HAS_FPU) begin : g_fp
      assign fp_ok = 1'b1;
    end else begin : g_nofp
      assign fp_ok = 1'b0;
    end
  endgenerate

  assign rd_p    = widen(c[4:2]);
  assign rs1_p   = widen(c[9:7]);
  assign spn_imm = {c[10:7], c[12:11], c[5], c[6], 2'b00};
  assign w_off   = {c[5], c[12:10], c[6], 2'b00};
  assign d_off   = {c[6:5], c[12:10], 3'b000};

  always_comb begin
    res.instr = NOP_WORD;
    res.bad   = 1'b0;
    unique case (c[15:13])
      3'b000: begin
        res.instr = enc_i({2'b00, spn_imm}, X2, 3'b000, rd_p, OPC_OPIMM);
        res.bad   = (spn_imm == 10'd0);
      end
      3'b001: begin
        res.instr = enc_i({4'b0, d_off}, rs1_p, 3'b011, rd_p, OPC_LOADFP);
        res.bad   = !fp_ok;
      end
      3'b010: res.instr = enc_i({5'b0, w_off}, rs1_p, 3'b010, rd_p, OPC_LOAD);
      3'b011: begin
        res.instr = enc_i({5'b0, w_off}, rs1_p, 3'b010, rd_p, OPC_LOADFP);
        res.bad   = !fp_ok;
      end
      3'b101: begin
        res.instr = enc_s({4'b0, d_off}, rd_p, rs1_p, 3'b011, OPC_STOREFP);
        res.bad   = !fp_ok;
      end
      3'b110: res.instr = enc_s({5'b0, w_off}, rd_p, rs1_p, 3'b010, OPC_STORE);
      3'b111: begin
        res.instr = enc_s({5'b0, w_off}, rd_p, rs1_p, 3'b010, OPC_STOREFP);
        res.bad   = !fp_ok;
      end
      default: res.bad = 1'b1;
    endcase
  end

endmodule

// File: rtl/rvc_quad1.sv
module rvc_quad1
  import rvc_pkg::*;
(
  input  logic [15:2] c,
  output xlat_t       res
);

  reg_t        rd_f;
  reg_t        rd_p;
  reg_t        rs2_p;
  logic [11:0] ci_imm;
  logic [11:0] j_off;
  logic [8:0]  b_off;
  logic [9:0]  sp_imm;
  logic [19:0] up_imm;
  logic        imm_nz;

  assign rd_f   = c[11:7];
  assign rd_p   = widen(c[9:7]);
  assign rs2_p  = widen(c[4:2]);
  assign ci_imm = {{6{c[12]}}, c[12], c[6:2]};
  assign j_off  = {c[12], c[8], c[10:9], c[6], c[7], c[2], c[11], c[5:3], 1'b0};
  assign b_off  = {c[12], c[6:5], c[2], c[11:10], c[4:3], 1'b0};
  assign sp_imm = {c[12], c[4:3], c[5], c[2], c[6], 4'b0000};
  assign up_imm = {{14{c[12]}}, c[12], c[6:2]};
  assign imm_nz = c[12] | (|c[6:2]);

  always_comb begin
    res.instr = NOP_WORD;
    res.bad   = 1'b0;
    unique case (c[15:13])
      3'b000: res.instr = enc_i(ci_imm, rd_f, 3'b000, rd_f, OPC_OPIMM);
      3'b001: res.instr = enc_j({{9{j_off[11]}}, j_off}, X1);
      3'b010: res.instr = enc_i(ci_imm, X0, 3'b000, rd_f, OPC_OPIMM);
      3'b011: begin
        if (rd_f == X2) begin
          res.instr = enc_i({{2{sp_imm[9]}}, sp_imm}, X2, 3'b000, X2, OPC_OPIMM);
        end else begin
          res.instr = {up_imm, rd_f, OPC_LUI};
        end
        res.bad = !imm_nz;
      end
      3'b100: begin
        unique case (c[11:10])
          2'b00: begin
            res.instr = enc_i({7'b0000000, c[6:2]}, rd_p, 3'b101, rd_p, OPC_OPIMM);
            res.bad   = c[12];
          end
          2'b01: begin
            res.instr = enc_i({7'b0100000, c[6:2]}, rd_p, 3'b101, rd_p, OPC_OPIMM);
            res.bad   = c[12];
          end
          2'b10: res.instr = enc_i(ci_imm, rd_p, 3'b111, rd_p, OPC_OPIMM);
          default: begin
            res.bad = c[12];
            unique case (c[6:5])
              2'b00:   res.instr = enc_r(7'b0100000, rs2_p, rd_p, 3'b000, rd_p);
              2'b01:   res.instr = enc_r(7'b0000000, rs2_p, rd_p, 3'b100, rd_p);
              2'b10:   res.instr = enc_r(7'b0000000, rs2_p, rd_p, 3'b110, rd_p);
              default: res.instr = enc_r(7'b0000000, rs2_p, rd_p, 3'b111, rd_p);
            endcase
          end
        endcase
      end
      3'b101: res.instr = enc_j({{9{j_off[11]}}, j_off}, X0);
      3'b110: res.instr = enc_b({{4{b_off[8]}}, b_off}, widen(c[9:7]), 3'b000);
      default: res.instr = enc_b({{4{b_off[8]}}, b_off}, widen(c[9:7]), 3'b001);
    endcase
  end

endmodule

// File: rtl/rvc_quad2.sv
module rvc_quad2
  import rvc_pkg::*;
#(
  parameter bit HAS_FPU = 1'b1
) (
  input  logic [15:2] c,
  output xlat_t       res
);

  logic       fp_ok;
  reg_t       rd_f;
  reg_t       rs2_f;
  logic [8:0] ld_d_off;
  logic [7:0] ld_w_off;
  logic [8:0] st_d_off;
  logic [7:0] st_w_off;

  generate
    if (HAS_FPU) begin : g_fp
      assign fp_ok = 1'b1;
    end else begin : g_nofp
      assign fp_ok = 1'b0;
    end
  endgenerate

  assign rd_f     = c[11:7];
  assign rs2_f    = c[6:2];
  assign ld_d_off = {c[4:2], c[12], c[6:5], 3'b000};
  assign ld_w_off = {c[3:2], c[12], c[6:4], 2'b00};
  assign st_d_off = {c[9:7], c[12:10], 3'b000};
  assign st_w_off = {c[8:7], c[12:9], 2'b00};

  always_comb begin
    res.instr = NOP_WORD;
    res.bad   = 1'b0;
    unique case (c[15:13])
      3'b000: begin
        res.instr = enc_i({7'b0000000, c[6:2]}, rd_f, 3'b001, rd_f, OPC_OPIMM);
        res.bad   = c[12];
      end
      3'b001: begin
        res.instr = enc_i({3'b000, ld_d_off}, X2, 3'b011, rd_f, OPC_LOADFP);
        res.bad   = !fp_ok;
      end
      3'b010: begin
        res.instr = enc_i({4'b0000, ld_w_off}, X2, 3'b010, rd_f, OPC_LOAD);
        res.bad   = (rd_f == X0);
      end
      3'b011: begin
        res.instr = enc_i({4'b0000, ld_w_off}, X2, 3'b010, rd_f, OPC_LOADFP);
        res.bad   = !fp_ok;
      end
      3'b100: begin
        if (rs2_f != X0) begin
          res.instr = enc_r(7'b0000000, rs2_f, c[12] ? rd_f : X0, 3'b000, rd_f);
        end else if (rd_f == X0) begin
          res.instr = EBREAK_WORD;
          res.bad   = !c[12];
        end else begin
          res.instr = enc_i(12'h000, rd_f, 3'b000, c[12] ? X1 : X0, OPC_JALR);
        end
      end
      3'b101: begin
        res.instr = enc_s({3'b000, st_d_off}, rs2_f, X2, 3'b011, OPC_STOREFP);
        res.bad   = !fp_ok;
      end
      3'b110: res.instr = enc_s({4'b0000, st_w_off}, rs2_f, X2, 3'b010, OPC_STORE);
      default: begin
        res.instr = enc_s({4'b0000, st_w_off}, rs2_f, X2, 3'b010, OPC_STOREFP);
        res.bad   = !fp_ok;
      end
    endcase
  end

endmodule

// File: rtl/rvc_expander.sv
module rvc_expander
  import rvc_pkg::*;
#(
  parameter int ILEN    = 32,
  parameter int CLEN    = 16,
  parameter bit HAS_FPU = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [ILEN-1:0] fetch_word_i,
  output logic [ILEN-1:0] expanded_o,
  output logic            wide_o,
  output logic            illegal_o
);

  localparam int QB = 2;
  localparam int NQ = 1 << QB;

  xlat_t            quad_res [NQ-1];
  xlat_t            pick;
  logic             next_wide;
  logic [ILEN-1:0]  next_word;
  logic [CLEN-1:0]  half;

  assign half = fetch_word_i[CLEN-1:0];

  rvc_quad0 #(.HAS_FPU(HAS_FPU)) u_q0 (.c(half[CLEN-1:2]), .res(quad_res[0]));
  rvc_quad1                      u_q1 (.c(half[CLEN-1:2]), .res(quad_res[1]));
  rvc_quad2 #(.HAS_FPU(HAS_FPU)) u_q2 (.c(half[CLEN-1:2]), .res(quad_res[2]));

  assign next_wide = &half[QB-1:0];

  always_comb begin
    pick = '{instr: NOP_WORD, bad: 1'b0};
    if (!next_wide) pick = quad_res[half[QB-1:0]];
    if (next_wide)     next_word = fetch_word_i;
    else if (pick.bad) next_word = NOP_WORD;
    else               next_word = pick.instr;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      expanded_o <= NOP_WORD;
      wide_o     <= 1'b0;
      illegal_o  <= 1'b0;
    end else begin
      expanded_o <= next_word;
      wide_o     <= next_wide;
      illegal_o  <= !next_wide && pick.bad;
    end
  end

  // R1: full-width words pass through unchanged
  p_pass_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    (fetch_word_i[1:0] == 2'b11) |=>
      (expanded_o == $past(fetch_word_i) && wide_o && !illegal_o));

  // R2: illegal output is the canonical nop; opcode low bits always 11
  p_bad_is_nop_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    illegal_o |-> (expanded_o == NOP_WORD && !wide_o));

  p_low_bits_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (expanded_o[1:0] == 2'b11));

  // R4: the all-zero halfword is never legal
  p_zero_half_r4: assert property (@(posedge clk_i) disable iff (rst_i)
    (fetch_word_i[15:0] == 16'h0000) |=> illegal_o);

  // R6: compressed jump-and-link writes x1
  p_jal_link_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (fetch_word_i[1:0] == 2'b01 && fetch_word_i[15:13] == 3'b001) |=>
      (expanded_o[11:7] == X1 && expanded_o[6:0] == OPC_JAL));

  // R9: stack word load into x0 is rejected
  p_lwsp_x0_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    (fetch_word_i[1:0] == 2'b10 && fetch_word_i[15:13] == 3'b010 &&
     fetch_word_i[11:7] == 5'd0) |=> illegal_o);

  // R10: word-sized register-register forms are rejected
  p_regreg_word_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    (fetch_word_i[1:0] == 2'b01 && fetch_word_i[15:10] == 6'b100111) |=> illegal_o);

  // R11: the breakpoint pattern
  p_ebreak_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    (fetch_word_i[15:0] == 16'h9002) |=> (expanded_o == EBREAK_WORD && !illegal_o));

endmodule

// File: tb/sim_rvc_expander.sv
module sim_rvc_expander;

  localparam logic [6:0] LD   = 7'b0000011;
  localparam logic [6:0] LDF  = 7'b0000111;
  localparam logic [6:0] OPI  = 7'b0010011;
  localparam logic [6:0] ST   = 7'b0100011;
  localparam logic [6:0] STF  = 7'b0100111;
  localparam logic [6:0] OPR  = 7'b0110011;
  localparam logic [6:0] LUIO = 7'b0110111;
  localparam logic [6:0] JALO = 7'b1101111;
  localparam logic [6:0] JRO  = 7'b1100111;
  localparam logic [31:0] NOP = 32'h0000_0013;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fw  = 32'h0;
  logic [31:0] exp_o;
  logic        wide_o;
  logic        ill_o;
  int          n_run  = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;

  rvc_expander u0 (
    .clk_i(clk), .rst_i(rst), .fetch_word_i(fw),
    .expanded_o(exp_o), .wide_o(wide_o), .illegal_o(ill_o)
  );

  function automatic logic [31:0] fi(input int imm, input int rs1, input int f3,
                                     input int rd, input logic [6:0] op);
    logic [11:0] im = imm[11:0];
    return {im, rs1[4:0], f3[2:0], rd[4:0], op};
  endfunction

  function automatic logic [31:0] fs(input int imm, input int rs2, input int rs1,
                                     input int f3, input logic [6:0] op);
    logic [11:0] im = imm[11:0];
    return {im[11:5], rs2[4:0], rs1[4:0], f3[2:0], im[4:0], op};
  endfunction

  function automatic logic [31:0] fr(input int f7, input int rs2, input int rs1,
                                     input int f3, input int rd);
    return {f7[6:0], rs2[4:0], rs1[4:0], f3[2:0], rd[4:0], OPR};
  endfunction

  function automatic logic [31:0] fb(input int imm, input int rs1, input int f3);
    logic [12:0] im = imm[12:0];
    return {im[12], im[10:5], 5'd0, rs1[4:0], f3[2:0], im[4:1], im[11], 7'b1100011};
  endfunction

  function automatic logic [31:0] fj(input int imm, input int rd);
    logic [20:0] im = imm[20:0];
    return {im[20], im[10:1], im[11], im[19:12], rd[4:0], JALO};
  endfunction

  task automatic compare(input logic [31:0] ew, input logic eb, input logic ewide,
                         input string req);
    n_run++;
    if (exp_o !== ew || ill_o !== eb || wide_o !== ewide) begin
      n_fail++;
      $display("FAIL %s: got word=%08h ill=%0b wide=%0b, expected word=%08h ill=%0b wide=%0b",
               req, exp_o, ill_o, wide_o, ew, eb, ewide);
    end
  endtask

  // compressed halfword with unrelated upper bits (R1: upper half ignored)
  task automatic chk_c(input logic [15:0] c, input logic [31:0] ew, input logic eb,
                       input string req);
    @(negedge clk);
    fw = {16'hA5C3, c};
    @(negedge clk);
    compare(eb ? NOP : ew, eb, 1'b0, req);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    fw  = 32'h0000_3FFD;
    repeat (3) @(negedge clk);
    compare(NOP, 1'b0, 1'b0, "R2 reset");
    rst = 1'b0;
  endtask

  task automatic t_pass;
    @(negedge clk); fw = 32'h1234_5677;
    @(negedge clk); compare(32'h1234_5677, 1'b0, 1'b1, "R1 pass");
    @(negedge clk); fw = 32'hFFFF_FFFF;
    @(negedge clk); compare(32'hFFFF_FFFF, 1'b0, 1'b1, "R1 pass ones");
  endtask

  task automatic t_spadd4;
    chk_c(16'h1FE4, fi(1020, 2, 0, 9, OPI), 1'b0, "R4 addi4spn max, R3 rd x9");
    chk_c(16'h0040, fi(4, 2, 0, 8, OPI), 1'b0, "R4 addi4spn 4");
    chk_c(16'h0004, NOP, 1'b1, "R4 zero imm");
    chk_c(16'h0000, NOP, 1'b1, "R4 all zero");
    chk_c(16'h8000, NOP, 1'b1, "R4 reserved q0");
  endtask

  task automatic t_words;
    chk_c(16'h41E8, fi(68, 11, 2, 10, LD), 1'b0, "R5 lw off 68, R3");
    chk_c(16'h5C00, fi(56, 8, 2, 8, LD), 1'b0, "R5 lw off 56");
    chk_c(16'hDFF4, fs(124, 13, 15, 2, ST), 1'b0, "R5 sw off 124");
  endtask

  task automatic t_jumps;
    chk_c(16'h3FFD, fj(-2, 1), 1'b0, "R6 jal -2");
    chk_c(16'hAFFD, fj(2046, 0), 1'b0, "R6 j 2046");
    chk_c(16'hA005, fj(32, 0), 1'b0, "R6 j 32");
    chk_c(16'hA801, fj(16, 0), 1'b0, "R6 j 16");
  endtask

  task automatic t_branches;
    chk_c(16'hD081, fb(-256, 9, 0), 1'b0, "R7 beqz -256");
    chk_c(16'hE00D, fb(34, 8, 1), 1'b0, "R7 bnez 34");
  endtask

  task automatic t_upper;
    chk_c(16'h7281, {20'hFFFE0, 5'd5, LUIO}, 1'b0, "R8 lui neg");
    chk_c(16'h6281, NOP, 1'b1, "R8 lui zero");
    chk_c(16'h6141, fi(16, 2, 0, 2, OPI), 1'b0, "R8 addi16sp 16");
    chk_c(16'h7101, fi(-512, 2, 0, 2, OPI), 1'b0, "R8 addi16sp -512");
    chk_c(16'h6101, NOP, 1'b1, "R8 addi16sp zero");
  endtask

  task automatic t_reject;
    chk_c(16'h4002, NOP, 1'b1, "R9 lwsp x0");
    chk_c(16'h50FE, fi(252, 2, 2, 1, LD), 1'b0, "R9 lwsp 252");
    chk_c(16'h8002, NOP, 1'b1, "R9 jr x0");
    chk_c(16'h8082, fi(0, 1, 0, 0, JRO), 1'b0, "R11 jr x1");
    chk_c(16'h9282, fi(0, 5, 0, 1, JRO), 1'b0, "R11 jalr x5");
  endtask

  task automatic t_regreg;
    chk_c(16'h8C05, fr(32, 9, 8, 0, 8), 1'b0, "R10 sub");
    chk_c(16'h8FB9, fr(0, 14, 15, 4, 15), 1'b0, "R10 xor");
    chk_c(16'h8D4D, fr(0, 11, 10, 6, 10), 1'b0, "R10 or");
    chk_c(16'h8E75, fr(0, 13, 12, 7, 12), 1'b0, "R10 and");
    chk_c(16'h9C05, NOP, 1'b1, "R10 word form");
  endtask

  task automatic t_misc;
    chk_c(16'h0001, NOP, 1'b0, "R11 nop");
    chk_c(16'h9002, 32'h0010_0073, 1'b0, "R11 ebreak");
    chk_c(16'h8192, fr(0, 4, 0, 0, 3), 1'b0, "R11 mv");
    chk_c(16'h9192, fr(0, 4, 3, 0, 3), 1'b0, "R11 add");
  endtask

  task automatic t_shifts;
    chk_c(16'h037E, fi(31, 6, 1, 6, OPI), 1'b0, "R12 slli 31");
    chk_c(16'h137E, NOP, 1'b1, "R12 slli bit5");
    chk_c(16'h808D, fi(3, 9, 5, 9, OPI), 1'b0, "R12 srli");
    chk_c(16'h848D, fi(32'h403, 9, 5, 9, OPI), 1'b0, "R12 srai");
    chk_c(16'h908D, NOP, 1'b1, "R12 srli bit5");
    chk_c(16'h98FD, fi(-1, 9, 7, 9, OPI), 1'b0, "R12 andi -1");
    chk_c(16'h12FD, fi(-1, 5, 0, 5, OPI), 1'b0, "R12 addi -1");
    chk_c(16'h4395, fi(5, 0, 0, 7, OPI), 1'b0, "R12 li 5");
  endtask

  task automatic t_float;
    chk_c(16'h3C60, fi(248, 8, 3, 8, LDF), 1'b0, "R13 fld, R3 f8");
    chk_c(16'hE0C8, fs(4, 10, 9, 2, STF), 1'b0, "R13 fsw");
    chk_c(16'hBF8E, fs(504, 3, 2, 3, STF), 1'b0, "R13 fsdsp");
    chk_c(16'h6212, fi(4, 2, 2, 4, LDF), 1'b0, "R13 flwsp");
    chk_c(16'hDF86, fs(252, 1, 2, 2, ST), 1'b0, "R5 swsp 252");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_pass();
    t_spadd4();
    t_words();
    t_jumps();
    t_branches();
    t_upper();
    t_reject();
    t_regreg();
    t_misc();
    t_shifts();
    t_float();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule